// File: doc/BRIEF.md
# RTC Periodic Interrupt Controller

This block is the periodic-interrupt part of a real-time clock. An external prescaler delivers a single-cycle strobe, `tick_256hz`, once every 1/256 second. The block counts these strobes and raises a sticky periodic flag whenever the selected interval elapses. An interrupt output follows that flag one cycle later, as long as a nonzero interval is selected.

Software reaches the block through an 8-bit control register on a simple write-strobe bus and reads it back combinationally on `ctl_rdata`. The register holds the periodic flag, a 3-bit interval code, a clock-enable bit, an adjust bit, a divider-clear bit and a run bit. The adjust and enable bits are only stored here, because the logic that uses them sits elsewhere.

There are two synchronous active-low resets. The power-on reset (also used on deep-standby entry) loads the register with 0x09. The manual reset clears the register but keeps the enable and run bits. Software standby is the case where neither reset is asserted, so the register keeps its contents.

Top module: `rtc_periodic_irq`

## Requirements
- R1: While `por_n` is low at a clock edge, the register reads 0x09 (bit 3 enable = 1, bit 0 run = 1, all other bits 0) after that edge, the tick count is zero and `pirq` is 0.
- R2: A write (`ctl_we` high at an edge) loads bits 6:4 (interval code), bit 3 (enable), bit 2 (adjust) and bit 0 (run) from `ctl_wdata`, and the new value is visible on `ctl_rdata` after that edge.
- R3: While `mrst_n` is low (and `por_n` high) at an edge, bit 7, bits 6:4, bit 2 and bit 1 become 0, and bits 3 and 0 keep their values.
- R4: With both resets high and no write, the interval code, enable, adjust and run bits hold their values indefinitely (standby retention).
- R5: Interval code c in bits 6:4 gives a period event every N ticks counted from a cleared count, with N = 1, 4, 16, 64, 128, 256, 512 for c = 1..7. An event sets the flag (bit 7) at the edge that consumes the N-th tick.
- R6: Bit 7 is set by a period event or by a write of 1, and cleared by a write of 0. When an event and a write of 0 fall on the same edge, the flag reads 1.
- R7: While the run bit (bit 0) is 0, ticks neither advance the count nor cause events. After run returns to 1, counting resumes from the held value.
- R8: Writing 1 to bit 1 makes it read 1 for one cycle. At the next edge the tick count is cleared and bit 1 reads 0.
- R9: `pirq` equals, one cycle late, the flag ANDed with a nonzero interval code. Either reset drives it to 0.
- R10: With interval code 000, no tick ever sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on / deep-standby reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| tick_256hz | input | 1 | One-cycle strobe every 1/256 s from the prescaler |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Current register contents |
| pirq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `tick_256hz` and `ctl_we` are sampled only at rising edges and are free of X once `por_n` has been released. They also assume that the power-on reset takes priority over the manual reset. The stimulus changes every input only on falling edges and asserts `por_n` first, for two cycles. It overlaps the manual reset with writes and ticks only in the random phase, where a reference model checks the prioritisation rather than the assertions. Ticks may arrive on consecutive cycles, which the counter takes in its stride, so the long intervals can be reached quickly.

// File: rtl/rtc_pi_pkg.sv
// Shared constants, register layout and interval decode for the periodic
// interrupt controller. Assumes a 9-bit tick count covering 2 s at 256 Hz.
package rtc_pi_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 3;
    localparam int CNT_W = 9;
    localparam logic [REG_W-1:0] POR_VALUE = 8'h09;

    // Register layout; bit positions are software-visible.
    typedef struct packed {
        logic             flag;  // bit 7
        logic [SEL_W-1:0] sel;   // bits 6:4
        logic             en;    // bit 3
        logic             adj;   // bit 2
        logic             drst;  // bit 1
        logic             run;   // bit 0
    } ctrl_t;

    // Number of low count bits that must roll over for a given code.
    function automatic int unsigned sel_bits(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 9;
            default: return 0;
        endcase
    endfunction

    // Mask of count bits that must all be zero after an increment.
    function automatic logic [CNT_W-1:0] sel_mask(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(sel_bits(sel))) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/rtc_pi_tickcnt.sv
// Tick counter and period-event detector.
// Counts 1/256 s strobes while run is high, clears on request, and flags an
// event when the low bits chosen by the interval code roll over to zero.
// Assumes tick is a single-cycle strobe sampled at the rising edge.
module rtc_pi_tickcnt
    import rtc_pi_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          mrst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          clr,
    input  logic [SW-1:0] sel,
    output logic [CW-1:0] cnt,
    output logic          period_ev
);
    logic          adv;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] mask;

    // Decode whether this edge advances the count and ends a period.
    always_comb begin
        adv       = tick & run & ~clr;
        cnt_inc   = cnt + CW'(1);
        mask      = CW'(sel_mask(SEL_W'(sel)));
        period_ev = adv & (sel != '0) & ((cnt_inc & mask) == '0);
    end

    // Count register: cleared by either reset or a divider clear.
    always_ff @(posedge clk) begin
        if (!por_n || !mrst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/rtc_pi_ctrlreg.sv
// Control register with two reset domains.
// Power-on reset loads the fixed value; manual reset clears all but the
// enable and run bits; the divider-clear bit self-clears after one cycle.
// Assumes period_ev is valid only when both resets are high.
module rtc_pi_ctrlreg
    import rtc_pi_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             period_ev,
    output ctrl_t            q
);
    ctrl_t wr_val;

    // View the write data in register layout.
    always_comb begin
        wr_val = ctrl_t'(wr_data);
    end

    // Register update: power-on, then manual reset, then event/write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            q <= ctrl_t'(POR_VALUE);
        end else if (!mrst_n) begin
            q.flag <= 1'b0;
            q.sel  <= '0;
            q.adj  <= 1'b0;
            q.drst <= 1'b0;
        end else begin
            q.flag <= period_ev | (wr_en ? wr_val.flag : q.flag);
            q.drst <= wr_en & wr_val.drst;
            if (wr_en) begin
                q.sel <= wr_val.sel;
                q.en  <= wr_val.en;
                q.adj <= wr_val.adj;
                q.run <= wr_val.run;
            end
        end
    end
endmodule

// File: rtl/rtc_periodic_irq.sv
// Periodic interrupt controller of a real-time clock.
// Joins the tick counter and the control register, and registers the
// interrupt request from the flag and a nonzero interval code.
// Assumes tick_256hz comes from an external 256 Hz prescaler.
module rtc_periodic_irq
    import rtc_pi_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             tick_256hz,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    output logic             pirq
);
    ctrl_t            ctrl;
    logic             period_ev;
    logic [CNT_W-1:0] tick_cnt;

    rtc_pi_tickcnt #(.CW(CNT_W), .SW(SEL_W)) u_cnt (
        .clk       (clk),
        .por_n     (por_n),
        .mrst_n    (mrst_n),
        .tick      (tick_256hz),
        .run       (ctrl.run),
        .clr       (ctrl.drst),
        .sel       (ctrl.sel),
        .cnt       (tick_cnt),
        .period_ev (period_ev)
    );

    rtc_pi_ctrlreg u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .mrst_n    (mrst_n),
        .wr_en     (ctl_we),
        .wr_data   (ctl_wdata),
        .period_ev (period_ev),
        .q         (ctrl)
    );

    // Read path is the register itself.
    always_comb begin
        ctl_rdata = REG_W'(ctrl);
    end

    // Interrupt request: flag qualified by a nonzero code, one cycle late.
    always_ff @(posedge clk) begin
        if (!por_n || !mrst_n) begin
            pirq <= 1'b0;
        end else begin
            pirq <= ctrl.flag & (ctrl.sel != '0);
        end
    end
endmodule

// File: rtl/rtc_pi_chk.sv
// Assertion checker for the periodic interrupt controller, bound to the top.
// Assumes inputs are X-free once the power-on reset has been applied.
module rtc_pi_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mrst_n,
    input logic       ctl_we,
    input logic       wr_flag,
    input logic [7:0] ctl_rdata,
    input logic       pirq,
    input logic       ev,
    input logic [8:0] cnt
);
    logic por_q;

    // Remember that the previous edge saw the power-on reset.
    always_ff @(posedge clk) begin
        por_q <= ~por_n;
    end

    // R1: after a power-on reset edge the register holds its load value.
    a_r1_por_value: assert property (@(posedge clk) disable iff (1'b0)
        por_q |-> (ctl_rdata == 8'h09 && cnt == 9'd0 && !pirq));

    // R3: manual reset clears all but enable and run, which are kept.
    a_r3_manual_keep: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> (ctl_rdata[7:4] == 4'd0 && ctl_rdata[2:1] == 2'd0 &&
                     ctl_rdata[3] == $past(ctl_rdata[3]) &&
                     ctl_rdata[0] == $past(ctl_rdata[0])));

    // R6: a period event always leaves the flag set.
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && ev) |=> ctl_rdata[7]);

    // R6: a write of 0 without an event clears the flag.
    a_r6_write0_clears: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && ctl_we && !wr_flag && !ev) |=> !ctl_rdata[7]);

    // R7: with run low and no divider clear the count is frozen.
    a_r7_hold_count: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && !ctl_rdata[0] && !ctl_rdata[1]) |=> $stable(cnt));

    // R8: the divider-clear bit clears the count and itself.
    a_r8_div_clear: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_rdata[1] && !(ctl_we && wr_flag === 1'bx)) |=> (cnt == 9'd0));

    // R9: the request follows the qualified flag one cycle later.
    a_r9_irq_follow: assert property (@(posedge clk) disable iff (!por_n)
        mrst_n |=> (pirq == ($past(ctl_rdata[7]) && ($past(ctl_rdata[6:4]) != 3'd0))));

    // R10: code 000 never produces a period event.
    a_r10_no_event: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_rdata[6:4] == 3'd0) |-> !ev);
endmodule

bind rtc_periodic_irq rtc_pi_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .ctl_we    (ctl_we),
    .wr_flag   (ctl_wdata[7]),
    .ctl_rdata (ctl_rdata),
    .pirq      (pirq),
    .ev        (period_ev),
    .cnt       (tick_cnt)
);

// File: tb/sim_rtc_periodic_irq.sv
module sim_rtc_periodic_irq;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst_n = 1'b1;
    logic       tick_256hz = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       pirq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0] m_reg = 8'h00;
    int         m_cnt = 0;
    logic       m_irq = 1'b0;
    bit         m_valid = 1'b0;

    always #5 clk = ~clk;

    rtc_periodic_irq u0 (
        .clk        (clk),
        .por_n      (por_n),
        .mrst_n     (mrst_n),
        .tick_256hz (tick_256hz),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .pirq       (pirq)
    );

    function automatic int period_of(input logic [2:0] code);
        if (code == 3'd0) return 0;
        if (code <= 3'd4) return 1 << (2 * (int'(code) - 1));
        return 1 << (int'(code) + 2);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at each rising edge from the driven inputs.
    always @(posedge clk) begin
        int  per;
        bit  adv, ev, nflag;
        int  ncnt;
        if (!por_n) begin
            m_reg = 8'h09; m_cnt = 0; m_irq = 1'b0; m_valid = 1'b1;
        end else if (!mrst_n) begin
            m_reg = {4'b0000, m_reg[3], 2'b00, m_reg[0]}; m_cnt = 0; m_irq = 1'b0;
        end else begin
            per   = period_of(m_reg[6:4]);
            adv   = tick_256hz && m_reg[0] && !m_reg[1];
            ev    = adv && per != 0 && ((m_cnt + 1) % per == 0);
            m_irq = m_reg[7] && (m_reg[6:4] != 3'd0);
            nflag = ev || (ctl_we ? ctl_wdata[7] : m_reg[7]);
            ncnt  = m_reg[1] ? 0 : (adv ? (m_cnt + 1) % 512 : m_cnt);
            if (ctl_we) m_reg = {nflag, ctl_wdata[6:0]};
            else        m_reg = {nflag, m_reg[6:2], 1'b0, m_reg[0]};
            m_cnt = ncnt;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            check(ctl_rdata[7] === m_reg[7], "R6 flag", ctl_rdata[7], m_reg[7]);
            check({ctl_rdata[6:2], ctl_rdata[0]} === {m_reg[6:2], m_reg[0]},
                  "R2 fields", ctl_rdata, m_reg);
            check(ctl_rdata[1] === m_reg[1], "R8 divider bit", ctl_rdata[1], m_reg[1]);
            check(pirq === m_irq, "R9 pirq", pirq, m_irq);
        end
    end

    // One cycle with the given write and tick, returning at the next falling edge.
    task automatic cyc(input bit we, input logic [7:0] d, input bit tk);
        ctl_we = we; ctl_wdata = d; tick_256hz = tk;
        @(negedge clk);
        ctl_we = 1'b0; tick_256hz = 1'b0;
    endtask

    task automatic finish_up;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int per;
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(0, 8'h00, 0);
        cyc(0, 8'h00, 0);
        por_n = 1'b1;
        // R1
        check(ctl_rdata == 8'h09, "R1 por value", ctl_rdata, 8'h09);
        check(pirq == 1'b0, "R1 pirq low", pirq, 0);

        // R2: write loads fields
        cyc(1, 8'h3D, 0);
        check(ctl_rdata == 8'h3D, "R2 write", ctl_rdata, 8'h3D);
        // R4: standby retention
        repeat (20) cyc(0, 8'hFF, 0);
        check(ctl_rdata == 8'h3D, "R4 retention", ctl_rdata, 8'h3D);

        // R3: manual reset keeps enable and run
        cyc(1, 8'h5C, 0);
        mrst_n = 1'b0; cyc(0, 8'h00, 0); mrst_n = 1'b1;
        check(ctl_rdata == 8'h08, "R3 manual keep en", ctl_rdata, 8'h08);
        cyc(1, 8'hF5, 0);
        mrst_n = 1'b0; cyc(0, 8'h00, 0); mrst_n = 1'b1;
        check(ctl_rdata == 8'h01, "R3 manual keep run", ctl_rdata, 8'h01);

        // R6: write 1 sets, write 0 clears; R9: code 0 gives no request
        cyc(1, 8'h80, 0);
        check(ctl_rdata[7] == 1'b1, "R6 write 1 sets", ctl_rdata[7], 1);
        cyc(0, 8'h00, 0);
        check(pirq == 1'b0, "R9 code zero masks", pirq, 0);
        cyc(1, 8'h00, 0);
        check(ctl_rdata[7] == 1'b0, "R6 write 0 clears", ctl_rdata[7], 0);

        // R8: divider-clear bit reads 1 for one cycle
        cyc(1, 8'h1B, 0);
        check(ctl_rdata[1] == 1'b1, "R8 bit set", ctl_rdata[1], 1);
        cyc(0, 8'h00, 0);
        check(ctl_rdata == 8'h19, "R8 bit self clears", ctl_rdata, 8'h19);

        // R5: each interval code from a cleared count
        for (int c = 1; c <= 7; c++) begin
            per = period_of(3'(c));
            v = {1'b0, 3'(c), 4'b1011};
            cyc(1, v, 0);
            cyc(0, 8'h00, 0);
            for (int t = 0; t < per - 1; t++) cyc(0, 8'h00, 1);
            check(ctl_rdata[7] == 1'b0, $sformatf("R5 code %0d early", c), ctl_rdata[7], 0);
            cyc(0, 8'h00, 1);
            check(ctl_rdata[7] == 1'b1, $sformatf("R5 code %0d period", c), ctl_rdata[7], 1);
            cyc(0, 8'h00, 0);
            check(pirq == 1'b1, $sformatf("R9 code %0d request", c), pirq, 1);
            cyc(1, {1'b0, 3'(c), 4'b1001}, 0);
        end

        // R6: event beats a write of 0 on the same edge
        cyc(1, 8'h1B, 0);
        cyc(0, 8'h00, 0);
        cyc(1, 8'h19, 1);
        check(ctl_rdata[7] == 1'b1, "R6 event wins", ctl_rdata[7], 1);

        // R7: run low freezes counting, resume continues from held value
        cyc(1, 8'h2B, 0);
        cyc(0, 8'h00, 0);
        cyc(0, 8'h00, 1);
        cyc(0, 8'h00, 1);
        cyc(1, 8'h28, 0);
        repeat (5) cyc(0, 8'h00, 1);
        check(ctl_rdata[7] == 1'b0, "R7 no event while stopped", ctl_rdata[7], 0);
        cyc(1, 8'h29, 0);
        cyc(0, 8'h00, 1);
        check(ctl_rdata[7] == 1'b0, "R7 held count third tick", ctl_rdata[7], 0);
        cyc(0, 8'h00, 1);
        check(ctl_rdata[7] == 1'b1, "R7 held count fourth tick", ctl_rdata[7], 1);

        // R9: reset clears the request
        cyc(0, 8'h00, 0);
        check(pirq == 1'b1, "R9 request up", pirq, 1);
        mrst_n = 1'b0; cyc(0, 8'h00, 0); mrst_n = 1'b1;
        check(pirq == 1'b0, "R9 manual reset clears", pirq, 0);

        // R10: code 000 never flags
        cyc(1, 8'h0B, 0);
        repeat (600) cyc(0, 8'h00, 1);
        check(ctl_rdata[7] == 1'b0, "R10 code zero silent", ctl_rdata[7], 0);

        // Constrained random phase, checked by the model each cycle
        for (int i = 0; i < 6000; i++) begin
            bit we, tk;
            we = ($urandom % 12) == 0;
            tk = ($urandom % 2) == 0;
            v  = 8'($urandom);
            if (($urandom % 4) != 0) v[6:4] = 3'(1 + $urandom % 3);
            if (($urandom % 3) != 0) v[1] = 1'b0;
            mrst_n = ($urandom % 300) != 0;
            if (i == 3000) por_n = 1'b0;
            cyc(we, v, tk);
            por_n = 1'b1; mrst_n = 1'b1;
        end
        finish_up();
    end
endmodule